// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Low-Pass FIR Filter

This block is a 32-tap low-pass FIR filter for 8-bit signed samples. It uses no multipliers. The taps are split into eight groups of four. For each group, a 16-entry constant table holds every possible sum of that group's four coefficients. One bit position of all stored samples is handled per clock, starting at the least significant bit. The four sample bits of a group at that position address the group's table. The eight table outputs are added together, weighted by the bit position, and accumulated.

After a sample is accepted, the filter spends eight clocks walking through the sample bits. It then emits the complete result, at full precision, with a one-cycle valid strobe. A new sample may be offered on the cycle that processes the final bit, so one sample can be filtered every eight clocks. A sample offered while the filter is busy with earlier bits is dropped. The coefficients are fixed constants inside the block.

Top module: `fir_da_top`

## Requirements
- R1: While `rstN` is low, and after reset until the first result, `outValid` is 0 and `outData` is 0. Reset also clears all 32 stored samples to zero.
- R2: Each result equals the sum over k = 0..31 of c[k]·x[n−k]. Here x[n] is the newest accepted sample and x[n−k] is the sample accepted k acceptances earlier, taken as zero before reset. Samples and the result are two's complement. `outData` carries the exact sum with no rounding.
- R3: The coefficients are symmetric, with c[k] = c[31−k]. For k = 0..15 they are −30, −34, −38, −35, −31, −40, −37, −32, −30, −42, −50, −45, 60, 160, 300, 470. This makes 12-bit signed words: 8 + ceil(log2(470/30)) = 12. The coefficients are reals scaled by 2^11−1 and truncated toward zero. Feeding a single 1 followed by zeros produces c[0], c[1], … c[31] on successive results.
- R4: `outData` is 8 + 12 + log2(32) = 25 bits wide. A history made entirely of −128 or entirely of 127 produces the exact product of that value with the coefficient sum, with no overflow.
- R5: A sample is accepted at the rising edge where `inValid` is sampled high while the block is ready. Its result appears with `outValid` high for exactly one cycle, after the 8th rising edge following the accepting edge.
- R6: A sample offered at any of the first seven bit-processing edges after an acceptance is ignored. It neither enters the history nor disturbs the result in progress.
- R7: A sample offered at the 8th edge after an acceptance is accepted at that edge. The same edge still completes the previous result, so samples can arrive every 8 clocks indefinitely.
- R8: `outData` changes only at edges that also raise `outValid`. Between pulses it holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Sample offer strobe |
| inData | input | 8 | Two's-complement input sample |
| outValid | output | 1 | One-cycle strobe marking a new result |
| outData | output | 25 | Two's-complement full-precision filter result |

## Verification
Two things can happen on the same edge: a new sample is accepted, and the previous sample's last bit (the sign bit, which is subtracted) is accumulated while its result is published. The bench provokes this by offering samples exactly eight clocks apart for long runs. Alongside, it offers samples on every cycle of a processing window, so that the dropped offers sit right next to the accepted one. A behavioural reference model tracks acceptance and the sample history with plain integers. It predicts `outValid` and `outData` for every clock. The overlap is judged correct only if the published result uses the old history while the following result includes the newly accepted sample.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;
  localparam int TAPS     = 32;
  localparam int GROUP_SZ = 4;
  localparam int GROUPS   = TAPS / GROUP_SZ;
  localparam int COEF_W   = 12;
  localparam int LUT_W    = COEF_W + $clog2(GROUP_SZ);
  localparam int SUM_W    = LUT_W + $clog2(GROUPS);
  localparam int SAMPLE_W = 8;
  localparam int IDX_W    = $clog2(SAMPLE_W);

  typedef struct packed {
    logic             load;
    logic             accum;
    logic             first;
    logic             last;
    logic [IDX_W-1:0] bitIdx;
  } daStrobe_t;

  function automatic int coefAt(int tap);
    int half;
    half = (tap < TAPS / 2) ? tap : TAPS - 1 - tap;
    case (half)
      0:  return -30;
      1:  return -34;
      2:  return -38;
      3:  return -35;
      4:  return -31;
      5:  return -40;
      6:  return -37;
      7:  return -32;
      8:  return -30;
      9:  return -42;
      10: return -50;
      11: return -45;
      12: return 60;
      13: return 160;
      14: return 300;
      15: return 470;
      default: return 0;
    endcase
  endfunction

  function automatic int lutEntry(int grp, int addr);
    int s;
    s = 0;
    for (int j = 0; j < GROUP_SZ; j++) begin
      if (((addr >> j) & 1) != 0) s = s + coefAt(grp * GROUP_SZ + j);
    end
    return s;
  endfunction
endpackage

// File: rtl/fir_da_lut.sv
module fir_da_lut #(
  parameter int GROUP  = 0,
  parameter int ADDR_W = 4,
  parameter int VAL_W  = 14
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [VAL_W-1:0] value
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic signed [VAL_W-1:0] rom [ENTRIES];

  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    localparam int ENT = fir_da_pkg::lutEntry(GROUP, k);
    assign rom[k] = VAL_W'(ENT);
  end

  assign value = rom[addr];
endmodule

// File: rtl/fir_da_ctrl.sv
module fir_da_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output fir_da_pkg::daStrobe_t stb
);
  localparam int IDX_W = fir_da_pkg::IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic             busy;
  logic [IDX_W-1:0] bitCnt;
  logic             onLast;
  logic             accept;

  assign onLast = busy && (bitCnt == LAST_IDX);
  assign accept = inValid && (!busy || onLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (onLast) begin
      busy   <= 1'b0;
    end else if (busy) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb.load   = accept;
    stb.accum  = busy;
    stb.first  = busy && (bitCnt == '0);
    stb.last   = onLast;
    stb.bitIdx = bitCnt;
  end
endmodule

// File: rtl/fir_da_datapath.sv
module fir_da_datapath #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 25
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fir_da_pkg::daStrobe_t stb,
  input  logic [DATA_W-1:0]     inData,
  output logic                  outValid,
  output logic [OUT_W-1:0]      outData
);
  import fir_da_pkg::*;

  logic [DATA_W-1:0]       taps [TAPS];
  logic [GROUP_SZ-1:0]     addr [GROUPS];
  logic signed [LUT_W-1:0] lutOut [GROUPS];
  logic signed [SUM_W-1:0] bitSum;
  logic signed [OUT_W-1:0] weighted;
  logic signed [OUT_W-1:0] base;
  logic signed [OUT_W-1:0] nextAcc;
  logic signed [OUT_W-1:0] acc;

  // sample history, newest at index 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (stb.load) begin
      taps[0] <= inData;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // one bit of each tap in a group forms that group's table address
  always_comb begin
    for (int g = 0; g < GROUPS; g++) begin
      for (int j = 0; j < GROUP_SZ; j++) begin
        addr[g][j] = taps[g*GROUP_SZ + j][stb.bitIdx];
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    fir_da_lut #(
      .GROUP (g),
      .ADDR_W(GROUP_SZ),
      .VAL_W (LUT_W)
    ) u_lut (
      .addr (addr[g]),
      .value(lutOut[g])
    );
  end

  always_comb begin
    bitSum = '0;
    for (int g = 0; g < GROUPS; g++) bitSum = bitSum + SUM_W'(lutOut[g]);
    weighted = OUT_W'(bitSum) <<< stb.bitIdx;
    base     = stb.first ? '0 : acc;
    nextAcc  = stb.last ? (base - weighted) : (base + weighted);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= 1'b0;
      if (stb.accum) acc <= nextAcc;
      if (stb.last) begin
        outValid <= 1'b1;
        outData  <= nextAcc;
      end
    end
  end
endmodule

// File: rtl/fir_da_top.sv
module fir_da_top #(
  parameter int DATA_W = fir_da_pkg::SAMPLE_W,
  localparam int OUT_W = DATA_W + fir_da_pkg::COEF_W + $clog2(fir_da_pkg::TAPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData
);
  fir_da_pkg::daStrobe_t stb;

  fir_da_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .stb    (stb)
  );

  fir_da_datapath #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: rtl/fir_da_checker.sv
module fir_da_checker #(
  parameter int OUT_W = 25
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  outValid,
  input logic [OUT_W-1:0]      outData,
  input fir_da_pkg::daStrobe_t stb
);
  localparam int IDX_W = fir_da_pkg::IDX_W;

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> outValid);

  p_valid_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stb.last));

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outData) |-> outValid);

  p_load_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (stb.accum && stb.first));

  p_bit_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accum && !stb.last && !stb.load) |=>
      (stb.accum && stb.bitIdx == IDX_W'($past(stb.bitIdx) + 1'b1)));

  p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.last && inValid) |-> stb.load);
endmodule

bind fir_da_top fir_da_checker #(.OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outData (outData),
  .stb     (stb)
);

// File: tb/fir_da_top_test.sv
`timescale 1ns/1ps
module fir_da_top_test;
  localparam int OUT_W = 25;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [7:0]       inData = '0;
  logic             outValid;
  logic [OUT_W-1:0] outData;

  int checks = 0;
  int failures = 0;
  string curTag = "R2";

  int cf [32];
  int hist [32];
  int cd = 0;
  int pendY = 0;
  bit expValid = 0;
  int expData = 0;

  always #2.5 clk = ~clk;

  fir_da_top uut (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

  function automatic int filt();
    int s;
    s = 0;
    for (int k = 0; k < 32; k++) s += cf[k] * hist[k];
    return s;
  endfunction

  task automatic step(input bit v, input int d);
    @(negedge clk);
    checks++;
    if (outValid !== expValid) begin
      failures++;
      $display("FAIL R5 outValid actual=%0b expected=%0b at %0t", outValid, expValid, $time);
    end
    checks++;
    if (outData !== OUT_W'(expData)) begin
      failures++;
      $display("FAIL %s outData actual=%0d expected=%0d at %0t",
               expValid ? curTag : "R8", $signed(outData), expData, $time);
    end
    inValid = v;
    inData  = 8'(d);
    expValid = (cd == 1);
    if (cd == 1) expData = pendY;
    if (cd > 0) cd--;
    if (v && cd == 0) begin
      for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
      pendY = filt();
      cd = 8;
    end
  endtask

  task automatic spaced(input int d);
    step(1'b1, d);
    for (int i = 0; i < 7; i++) step(1'b0, 0);
  endtask

  initial begin
    int base [16] = '{-30, -34, -38, -35, -31, -40, -37, -32,
                      -30, -42, -50, -45, 60, 160, 300, 470};
    for (int k = 0; k < 16; k++) begin
      cf[k] = base[k];
      cf[31-k] = base[k];
    end
    for (int k = 0; k < 32; k++) hist[k] = 0;

    repeat (4) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      failures++;
      $display("FAIL R1 reset outputs actual=%0b/%0d expected=0/0", outValid, outData);
    end
    rstN = 1'b1;

    // impulse response: first result after reset also shows a zeroed history (R1)
    curTag = "R3";
    spaced(1);
    for (int i = 0; i < 31; i++) spaced(0);

    // extreme histories
    curTag = "R4";
    for (int i = 0; i < 32; i++) spaced(-128);
    for (int i = 0; i < 32; i++) spaced(127);
    for (int i = 0; i < 32; i++) spaced(-128);

    // offers during the busy window are dropped; the 8th is taken
    curTag = "R6";
    for (int r = 0; r < 12; r++) begin
      step(1'b1, 17 * r - 90);
      for (int i = 0; i < 7; i++) step(1'b1, 113 - 31 * i);
    end

    // continuous offers, accepted every 8 clocks alongside the final bit
    curTag = "R7";
    for (int i = 0; i < 80; i++) step(1'b1, (i * 37) % 256 - 128);

    // random traffic
    curTag = "R2";
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) == 0, int'($urandom % 256) - 128);

    for (int i = 0; i < 12; i++) step(1'b0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule